// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds. Each clock cycle stands for one 16 ns quantum, so a running counter adds 16 on every cycle. To follow a clock-rate adjustment, software packs a trim word: an interval length counted in quanta, a step of 0 to 7 ns, and a sign. Once per interval the counter adds 16 plus or minus the step instead of 16. A software routine derives the trim word from a rate error. That routine, packet timestamp capture and packet classification are not part of this block.

A small word-addressed register port gives access to the block. Through it software can pause and resume the counter, preload all 64 bits in two 32-bit halves while paused, and read the time in two halves. Reading the low half also captures the matching high half, so the two reads form one consistent value. The trim word is guarded: it can only change while a separate hold bit is set. While that bit is set the interval counter stays at zero and no trims happen. The update sequence is to set the hold bit, read it back, write the trim word, then clear the hold bit.

Top module: `tsc_top`

## Requirements
- R1: After reset the counter is running (status read 0), the hold bit reads 0, the trim word reads 0, and the time advances from 0.
- R2: While running and with no trim due, the time rises by exactly 16 on each clock cycle.
- R3: Writing 2 to the control word (address 4) pauses the counter and writing 4 resumes it. Any other value is ignored. Reading address 4 returns the paused flag in bit 0. While paused the time does not change.
- R4: While paused, a write to address 2 replaces time bits 31:0 and a write to address 3 replaces bits 63:32. While running, such writes are ignored.
- R5: A read returns its data one cycle after the read strobe. Address 0 returns time bits 31:0 and, in the same cycle, captures bits 63:32. Address 1 returns that captured half.
- R6: Address 5 holds the drift hold bit: bit 0 of a write sets it, and a read returns it in bit 0.
- R7: The trim word at address 6 takes a write only while the hold bit is 1. Otherwise the write is ignored. Reads return the stored word.
- R8: The trim word packs the interval in quanta in bits 27:0, the step in ns in bits 30:28, and the sign in bit 31 (1 = add, 0 = subtract). Counting from resume or hold release, every interval-th running cycle adds 16 + step (or 16 − step).
- R9: A trim word with step 0 or interval 0 (including all zeros) gives no trims at all.
- R10: While the hold bit is 1 the interval counter is cleared and no trim is applied, even with a valid trim word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 16 ns quantum per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |

## Verification
Assertions check these rules on every cycle:
- a running cycle with no trim adds exactly one quantum;
- a paused counter holds its value unless a half is loaded;
- a set hold bit clears the interval count;
- a trim never fires with a zero step or interval;
- the interval count stays below the configured interval;
- the trim word only changes while held.

Only the bench scenarios can show the rest:
- the accumulated time after a number of running cycles, with trims added or subtracted at the right period;
- the consistency of the captured high half;
- that loads and trim writes are ignored at the wrong moment.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Strobes and levels sent from the control module to the datapath
  typedef struct packed {
    logic runEn;      // counter advances this cycle
    logic driftHold;  // trim logic held in reset
    logic loadLo;     // replace low half with loadWord
    logic loadHi;     // replace high half with loadWord
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ADDR_TIME_LO = 3'd0,
    ADDR_TIME_HI = 3'd1,
    ADDR_LOAD_LO = 3'd2,
    ADDR_LOAD_HI = 3'd3,
    ADDR_CTRL    = 3'd4,
    ADDR_HOLD    = 3'd5,
    ADDR_TRIM    = 3'd6,
    ADDR_SPARE   = 3'd7
  } regAddr_e;

  localparam int CMD_PAUSE  = 2;
  localparam int CMD_RESUME = 4;

endpackage

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28,
  parameter int STEP_W   = 3,
  parameter int QUANTUM  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [DATA_W-1:0]   loadWord,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [STEP_W-1:0]   stepCfg,
  input  logic                dirAdd,
  output logic [TIME_W-1:0]   timeNow
);

  localparam logic [TIME_W-1:0]   QUANT   = TIME_W'(QUANTUM);
  localparam logic [PERIOD_W-1:0] ONE_CNT = PERIOD_W'(1);

  logic [TIME_W-1:0]   timeQ;
  logic [PERIOD_W-1:0] intervalCnt;
  logic [TIME_W-1:0]   stepExt;
  logic [TIME_W-1:0]   addAmount;
  logic                corrEnable;
  logic                fire;

  assign stepExt    = TIME_W'(stepCfg);
  assign corrEnable = (stepCfg != '0) && (periodCfg != '0) && !ctrl.driftHold;
  assign fire       = ctrl.runEn && corrEnable && (intervalCnt == periodCfg - ONE_CNT);

  always_comb begin
    if (!fire)       addAmount = QUANT;
    else if (dirAdd) addAmount = QUANT + stepExt;
    else             addAmount = QUANT - stepExt;
  end

  // Interval counter: cleared while held or disabled, frozen while paused
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 intervalCnt <= '0;
    else if (!corrEnable)      intervalCnt <= '0;
    else if (ctrl.runEn)       intervalCnt <= fire ? '0 : intervalCnt + ONE_CNT;
  end

  // Time register with half-word preload while paused
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ <= '0;
    end else if (ctrl.runEn) begin
      timeQ <= timeQ + addAmount;
    end else begin
      if (ctrl.loadLo) timeQ[DATA_W-1:0]      <= loadWord;
      if (ctrl.loadHi) timeQ[TIME_W-1:DATA_W] <= loadWord;
    end
  end

  assign timeNow = timeQ;

  assert_step_quantum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.runEn && !fire) |=> timeNow == $past(timeNow) + QUANT);

  assert_paused_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.runEn && !ctrl.loadLo && !ctrl.loadHi) |=> $stable(timeNow));

  assert_hold_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.driftHold |=> intervalCnt == '0);

  assert_no_fire_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (stepCfg != '0 && periodCfg != '0));

  assert_interval_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    corrEnable |-> intervalCnt < periodCfg);

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int TIME_W   = 64,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28,
  parameter int STEP_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [2:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [TIME_W-1:0]   timeNow,
  output logic [DATA_W-1:0]   rdData,
  output dpCtrl_t             dpCtrl,
  output logic [DATA_W-1:0]   loadWord,
  output logic [PERIOD_W-1:0] periodCfg,
  output logic [STEP_W-1:0]   stepCfg,
  output logic                dirAdd
);

  localparam int STEP_LSB = PERIOD_W;
  localparam int DIR_BIT  = DATA_W - 1;
  localparam logic [DATA_W-1:0] PAUSE_WORD  = DATA_W'(CMD_PAUSE);
  localparam logic [DATA_W-1:0] RESUME_WORD = DATA_W'(CMD_RESUME);

  regAddr_e          addrE;
  logic              pausedQ;
  logic              holdQ;
  logic [DATA_W-1:0] trimQ;
  logic [DATA_W-1:0] snapHiQ;
  logic [DATA_W-1:0] rdDataQ;

  assign addrE = regAddr_e'(addr);

  // Control word, hold bit and guarded trim word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausedQ <= 1'b0;
      holdQ   <= 1'b0;
      trimQ   <= '0;
    end else if (wrEn) begin
      case (addrE)
        ADDR_CTRL: begin
          if (wrData == PAUSE_WORD)       pausedQ <= 1'b1;
          else if (wrData == RESUME_WORD) pausedQ <= 1'b0;
        end
        ADDR_HOLD: holdQ <= wrData[0];
        ADDR_TRIM: if (holdQ) trimQ <= wrData;
        default: ;
      endcase
    end
  end

  // Registered read port with high-half capture on low read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      snapHiQ <= '0;
    end else if (rdEn) begin
      case (addrE)
        ADDR_TIME_LO: begin
          rdDataQ <= timeNow[DATA_W-1:0];
          snapHiQ <= timeNow[TIME_W-1:DATA_W];
        end
        ADDR_TIME_HI: rdDataQ <= snapHiQ;
        ADDR_CTRL:    rdDataQ <= DATA_W'(pausedQ);
        ADDR_HOLD:    rdDataQ <= DATA_W'(holdQ);
        ADDR_TRIM:    rdDataQ <= trimQ;
        default:      rdDataQ <= '0;
      endcase
    end
  end

  assign rdData = rdDataQ;

  always_comb begin
    dpCtrl.runEn     = !pausedQ;
    dpCtrl.driftHold = holdQ;
    dpCtrl.loadLo    = wrEn && (addrE == ADDR_LOAD_LO) && pausedQ;
    dpCtrl.loadHi    = wrEn && (addrE == ADDR_LOAD_HI) && pausedQ;
  end

  assign loadWord  = wrData;
  assign periodCfg = trimQ[PERIOD_W-1:0];
  assign stepCfg   = trimQ[STEP_LSB +: STEP_W];
  assign dirAdd    = trimQ[DIR_BIT];

  assert_pause_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrE == ADDR_CTRL && wrData == PAUSE_WORD) |=> pausedQ);

  assert_resume_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrE == ADDR_CTRL && wrData == RESUME_WORD) |=> !pausedQ);

  assert_trim_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    !holdQ |=> $stable(trimQ));

  assert_hold_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrE == ADDR_HOLD) |=> holdQ == $past(wrData[0]));

endmodule

// File: rtl/tsc_top.sv
module tsc_top
  import tsc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28,
  parameter int STEP_W   = 3,
  parameter int QUANTUM  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  localparam int TIME_W = 2 * DATA_W;

  dpCtrl_t             dpCtrl;
  logic [DATA_W-1:0]   loadWord;
  logic [PERIOD_W-1:0] periodCfg;
  logic [STEP_W-1:0]   stepCfg;
  logic                dirAdd;
  logic [TIME_W-1:0]   timeNow;

  tsc_ctrl #(
    .TIME_W(TIME_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .STEP_W(STEP_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .rdEn(regRdEn), .addr(regAddr), .wrData(regWrData),
    .timeNow(timeNow), .rdData(regRdData), .dpCtrl(dpCtrl),
    .loadWord(loadWord), .periodCfg(periodCfg), .stepCfg(stepCfg), .dirAdd(dirAdd)
  );

  tsc_datapath #(
    .TIME_W(TIME_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W),
    .STEP_W(STEP_W), .QUANTUM(QUANTUM)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .loadWord(loadWord),
    .periodCfg(periodCfg), .stepCfg(stepCfg), .dirAdd(dirAdd), .timeNow(timeNow)
  );

endmodule

// File: tb/test_tsc_top.sv
`timescale 1ns/1ps
module test_tsc_top;

  localparam logic [2:0] A_TLO = 3'd0, A_THI = 3'd1, A_LLO = 3'd2, A_LHI = 3'd3,
                         A_CTRL = 3'd4, A_HOLD = 3'd5, A_TRIM = 3'd6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsc_top i_tsc_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d, output int edgeIdx);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    edgeIdx = cyc;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d, output int edgeIdx);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); @(negedge clk);
    edgeIdx = cyc;
    d = regRdData;
    regRdEn = 1'b0;
  endtask

  // Time after n running cycles from a load, per R2/R8/R9/R10
  function automatic logic [63:0] expectTime(input logic [63:0] load, input logic [31:0] trim,
                                              input bit held, input longint n);
    longint p = longint'(trim[27:0]);
    longint st = longint'(trim[30:28]);
    longint corr = 0;
    logic [63:0] t;
    if (st != 0 && p != 0 && !held) corr = n / p;
    t = load + 64'(n) * 64'd16;
    if (trim[31]) t = t + 64'(corr * st);
    else          t = t - 64'(corr * st);
    return t;
  endfunction

  task automatic runDrift(input logic [63:0] loadVal, input logic [31:0] trim,
                          input bit keepHold, input int waitCyc, input string req);
    int e, k, m;
    logic [31:0] lo, hi;
    wrReg(A_CTRL, 32'd2, e);
    wrReg(A_LLO, loadVal[31:0], e);
    wrReg(A_LHI, loadVal[63:32], e);
    wrReg(A_HOLD, 32'd1, e);
    wrReg(A_TRIM, trim, e);
    if (!keepHold) wrReg(A_HOLD, 32'd0, e);
    wrReg(A_CTRL, 32'd4, k);
    repeat (waitCyc) @(negedge clk);
    rdReg(A_TLO, lo, m);
    rdReg(A_THI, hi, e);
    check(req, {hi, lo}, expectTime(loadVal, trim, keepHold, longint'(m - k - 1)));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int e, k, m, c0;
    logic [31:0] d, lo, lo2, hi;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    c0 = cyc;

    // R1: reset state
    rdReg(A_CTRL, d, e); check("R1 status", 64'(d), 64'd0);
    rdReg(A_HOLD, d, e); check("R1 hold", 64'(d), 64'd0);
    rdReg(A_TRIM, d, e); check("R1 trim", 64'(d), 64'd0);
    rdReg(A_TLO, lo, m);
    rdReg(A_THI, hi, e);
    check("R1 R2 time from zero", {hi, lo}, 64'(m - c0 - 1) * 64'd16);

    // R3: pause freezes, status bit, other values ignored
    wrReg(A_CTRL, 32'd2, e);
    rdReg(A_TLO, lo, e);
    repeat (10) @(negedge clk);
    rdReg(A_TLO, lo2, e);
    check("R3 paused frozen", 64'(lo2), 64'(lo));
    wrReg(A_CTRL, 32'd3, e);
    rdReg(A_CTRL, d, e); check("R3 odd value ignored", 64'(d), 64'd1);
    wrReg(A_CTRL, 32'd4, e);
    rdReg(A_CTRL, d, e); check("R3 resumed", 64'(d), 64'd0);

    // R4: load ignored while running
    wrReg(A_CTRL, 32'd2, e);
    wrReg(A_LLO, 32'h1000_0000, e);
    wrReg(A_LHI, 32'h0000_0077, e);
    wrReg(A_CTRL, 32'd4, k);
    repeat (3) @(negedge clk);
    wrReg(A_LLO, 32'd0, e);
    wrReg(A_LHI, 32'd0, e);
    rdReg(A_TLO, lo, m);
    rdReg(A_THI, hi, e);
    check("R4 load while running ignored", {hi, lo},
          64'h0000_0077_1000_0000 + 64'(m - k - 1) * 64'd16);

    // R5: snapshot of high half across a low-half wrap
    wrReg(A_CTRL, 32'd2, e);
    wrReg(A_LLO, 32'hFFFF_FF00, e);
    wrReg(A_LHI, 32'h0000_0005, e);
    wrReg(A_CTRL, 32'd4, k);
    rdReg(A_TLO, lo, m);
    check("R5 low half", 64'(lo), 64'(32'hFFFF_FF00 + 32'(16 * (m - k - 1))));
    repeat (40) @(negedge clk);
    rdReg(A_THI, hi, e);
    check("R5 captured high half", 64'(hi), 64'd5);
    rdReg(A_TLO, lo, m);
    rdReg(A_THI, hi, e);
    check("R5 high after wrap", {hi, lo}, 64'h0000_0005_FFFF_FF00 + 64'(m - k - 1) * 64'd16);

    // R6 / R7: hold bit and guarded trim word
    wrReg(A_HOLD, 32'd1, e);
    rdReg(A_HOLD, d, e); check("R6 hold set", 64'(d), 64'd1);
    wrReg(A_TRIM, 32'hA000_0010, e);
    wrReg(A_HOLD, 32'd0, e);
    rdReg(A_HOLD, d, e); check("R6 hold clear", 64'(d), 64'd0);
    wrReg(A_TRIM, 32'h1234_5678, e);
    rdReg(A_TRIM, d, e); check("R7 trim write ignored", 64'(d), 64'hA000_0010);

    // R8 / R9 / R10 directed corners
    runDrift(64'h0000_0001_0000_0000, 32'hF000_0001, 1'b0, 20, "R8 add 7 every cycle");
    runDrift(64'h0000_0000_0000_1000, 32'h2000_0003, 1'b0, 31, "R8 sub 2 every 3");
    runDrift(64'h0000_0000_FFFF_FFF0, 32'h9000_0005, 1'b0, 44, "R8 add 1 every 5 with carry");
    runDrift(64'h0000_0000_0000_0000, 32'h0FFF_FFFF, 1'b0, 25, "R9 step zero");
    runDrift(64'h0000_0000_0000_0040, 32'h0000_0000, 1'b0, 25, "R9 all zero word");
    runDrift(64'h0000_0000_0000_0040, 32'hF000_0000, 1'b0, 25, "R9 interval zero");
    runDrift(64'h0000_0002_0000_0000, 32'hF000_0001, 1'b1, 25, "R10 held no trim");

    // Random scenarios (R2 R8 R9)
    for (int i = 0; i < 12; i++) begin
      logic [63:0] ld;
      logic [31:0] tw;
      ld = {$urandom(), $urandom()};
      tw = {$urandom_range(1, 0) == 1, 3'($urandom_range(7, 0)), 28'($urandom_range(12, 1))};
      runDrift(ld, tw, 1'b0, int'($urandom_range(60, 5)), "R8 random trim");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule